// File: doc/BRIEF.md
# AC-Link Frame Serializer

This block drives the outgoing serial data line of an AC97 link. It runs on the bit clock that the codec supplies and aligns itself to the rising edge of the frame sync input. Every frame is 256 bits long: a 16-bit tag slot comes first, and twelve 20-bit slots follow it. Each slot word is pulled from an external transmit FIFO through a ready/valid pop port and is shifted out most significant bit first. Output data changes on the rising bit-clock edge, so the far end can sample it on the falling edge.

A level input from the receive side, `cready`, reports whether the codec has flagged itself ready. The serializer samples this level at each frame start. A frame is sent only if `cready` was high at that instant, and the receive side raises `cready` only after a frame has already begun. As a result, sending starts one whole frame after the codec reports ready. If `cready` drops in the middle of a frame, the line goes quiet at the next bit and stays low until a later frame start sees `cready` high again.

In the tag word, bit 15 marks the frame valid, bits 14 and 13 mark the control address and control data slots valid, and bits 12 and 11 mark the left and right PCM slots valid. The serializer passes these bits through unchanged from the FIFO word.

Top module: `ac_link_frame_tx`

## Requirements
- R1: A frame starts at the first clock edge that sees `fsync` high after it was low. From that edge `bit_cnt` reads 0 and `slot_idx` reads 0, and `sdo` carries the first bit of the frame. Holding `fsync` high longer starts no further frame. A frame start can also cut a running frame short.
- R2: Slot 0 lasts 16 clocks and slots 1 to 12 last 20 clocks each. `slot_idx` runs from 0 to 12 and `bit_cnt` runs from 0 to 255. Both advance by one clock per bit.
- R3: Slot words go out MSB first. Slot 0 sends bits 15 down to 0 of its FIFO word. Slots 1 to 12 send bits 19 down to 0.
- R4: A frame whose start edge sees `cready` low keeps `sdo` low for all 256 bits and pops nothing.
- R5: `cready` rising in the middle of a frame has no effect on that frame. Sending begins with the next frame whose start edge sees `cready` high.
- R6: When `cready` is seen low at an edge inside a sending frame, `sdo` is low from that edge on. No later slot of that frame pops a word.
- R7: While sending, `tx_ready` is high in exactly the one cycle before each slot's first bit leaves. A word is popped when `tx_ready` and `tx_valid` are both high, giving 13 pops per full frame.
- R8: If `tx_valid` is low when a slot needs a word, that slot is sent as all zeros. `underrun` is then high for the one cycle in which the slot's first bit is on `sdo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsync | input | 1 | Frame sync; its rising edge starts a frame |
| cready | input | 1 | Codec-ready level from the receive path |
| tx_data | input | 20 | FIFO head word (slot 0 uses bits 15:0) |
| tx_valid | input | 1 | FIFO holds a word |
| tx_ready | output | 1 | Pop strobe for the FIFO head |
| sdo | output | 1 | Serial data out |
| underrun | output | 1 | One-cycle pulse: a slot was sent as zeros for lack of data |
| slot_idx | output | 4 | Slot of the bit currently on `sdo` |
| bit_cnt | output | 8 | Position in the frame of the bit currently on `sdo` |

## Verification
A wrong slot or bit position shows at the ports within one slot. `bit_cnt` and `slot_idx` drift from the bench's count, and every bit after the slip lands in the wrong place. A wrong gate state shows on `sdo` in the very next bit, as data during an idle frame or after `cready` falls. It shows in the FIFO pop count by the end of that frame. A stale shift register or a missed pop corrupts the MSB of the next slot, and the bench compares every bit of every frame against a word model that it keeps on its own.

// File: rtl/ac_link_frame_tx.sv
module ac_link_frame_tx #(
  parameter int TAG_W   = 16,
  parameter int SLOT_W  = 20,
  parameter int N_SLOTS = 13
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               fsync,
  input  logic                               cready,
  input  logic [SLOT_W-1:0]                  tx_data,
  input  logic                               tx_valid,
  output logic                               tx_ready,
  output logic                               sdo,
  output logic                               underrun,
  output logic [$clog2(N_SLOTS)-1:0]         slot_idx,
  output logic [$clog2(TAG_W + (N_SLOTS-1)*SLOT_W)-1:0] bit_cnt
);

  localparam int FRAME_LEN = TAG_W + (N_SLOTS-1)*SLOT_W;
  localparam int CW  = $clog2(FRAME_LEN);
  localparam int SIW = $clog2(N_SLOTS);
  localparam int PW  = $clog2(SLOT_W);
  localparam logic [PW-1:0]  TAG_LAST  = PW'(TAG_W-1);
  localparam logic [PW-1:0]  SLOT_LAST = PW'(SLOT_W-1);
  localparam logic [SIW-1:0] SLOT_MAX  = SIW'(N_SLOTS-1);

  logic              fs_q, on_q, sdo_q, und_q;
  logic [SIW-1:0]    slot_q, slot_n;
  logic [PW-1:0]     pos_q, pos_n, last_pos;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic [SLOT_W-1:0] sh_q, word;
  logic              fs_rise, slot_end, wrap, on_n, start_n, take;

  assign fs_rise  = fsync & ~fs_q;
  assign last_pos = (slot_q == '0) ? TAG_LAST : SLOT_LAST;
  assign slot_end = (pos_q == last_pos);
  assign wrap     = fs_rise | (slot_end & (slot_q == SLOT_MAX));
  assign slot_n   = wrap ? '0 : (slot_end ? slot_q + SIW'(1) : slot_q);
  assign pos_n    = (wrap | slot_end) ? '0 : pos_q + PW'(1);
  assign cnt_n    = wrap ? '0 : cnt_q + CW'(1);
  assign on_n     = wrap ? cready : (on_q & cready);
  assign start_n  = (pos_n == '0);
  assign tx_ready = start_n & on_n;
  assign take     = tx_ready & tx_valid;
  assign word     = !take ? '0 :
                    (slot_n == '0) ? {tx_data[TAG_W-1:0], {(SLOT_W-TAG_W){1'b0}}} : tx_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q   <= 1'b0;
      on_q   <= 1'b0;
      slot_q <= SLOT_MAX;
      pos_q  <= SLOT_LAST;
      cnt_q  <= CW'(FRAME_LEN-1);
      sh_q   <= '0;
      sdo_q  <= 1'b0;
      und_q  <= 1'b0;
    end else begin
      fs_q   <= fsync;
      on_q   <= on_n;
      slot_q <= slot_n;
      pos_q  <= pos_n;
      cnt_q  <= cnt_n;
      und_q  <= tx_ready & ~tx_valid;
      if (start_n) begin
        sdo_q <= on_n & word[SLOT_W-1];
        sh_q  <= {word[SLOT_W-2:0], 1'b0};
      end else begin
        sdo_q <= on_n & sh_q[SLOT_W-1];
        sh_q  <= {sh_q[SLOT_W-2:0], 1'b0};
      end
    end
  end

  assign sdo      = sdo_q;
  assign underrun = und_q;
  assign slot_idx = slot_q;
  assign bit_cnt  = cnt_q;

  p_sync_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fs_rise |=> (bit_cnt == '0 && slot_idx == '0));
  p_slot_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_idx <= SLOT_MAX);
  p_frame_head_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt == '0) |-> (slot_idx == '0));
  p_pop_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> (pos_q == '0));
  p_gate_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cready |=> !sdo);
  p_underrun_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> !sdo);

endmodule

// File: tb/sim_ac_link_frame_tx.sv
`timescale 1ns/1ps
module sim_ac_link_frame_tx;
  logic clk = 1'b0, rst_n = 1'b0, fsync = 1'b0, cready = 1'b0;
  logic [19:0] tx_data;
  logic tx_valid, tx_ready, sdo, underrun;
  logic [3:0] slot_idx;
  logic [7:0] bit_cnt;
  int n_chk = 0, n_bad = 0;
  int popped = 0, limit = 0, exp_pops = 0;

  always #4 clk = ~clk;

  ac_link_frame_tx u0 (.clk(clk), .rst_n(rst_n), .fsync(fsync), .cready(cready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .sdo(sdo),
    .underrun(underrun), .slot_idx(slot_idx), .bit_cnt(bit_cnt));

  function automatic logic [19:0] wgen(int i);
    return 20'((i * 40503 + 7) ^ (i << 13));
  endfunction

  assign tx_valid = (popped < limit);
  assign tx_data  = wgen(popped);
  always @(posedge clk) if (tx_ready && tx_valid) popped <= popped + 1;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (bit_cnt %0d)", tag, act, exp, bit_cnt);
    end
  endtask

  // {ready at frame start, drop bit, raise bit, words added}; 511 = no event
  localparam int NV = 9;
  localparam logic [27:0] VEC [NV] = '{
    {1'b0, 9'd511, 9'd511, 9'd20},
    {1'b0, 9'd511, 9'd100, 9'd0},
    {1'b1, 9'd511, 9'd511, 9'd0},
    {1'b1, 9'd511, 9'd511, 9'd13},
    {1'b1, 9'd511, 9'd511, 9'd0},
    {1'b1, 9'd120, 9'd511, 9'd30},
    {1'b0, 9'd511, 9'd511, 9'd0},
    {1'b0, 9'd511, 9'd3,   9'd0},
    {1'b1, 9'd511, 9'd511, 9'd0}
  };

  task automatic run_frame(logic [27:0] v);
    logic rdy0 = v[27];
    int drop = int'(v[26:18]);
    int raise = int'(v[17:9]);
    logic [19:0] w = '0;
    logic has = 1'b0;
    int pops0 = exp_pops;
    limit += int'(v[8:0]);
    cready = rdy0;
    fsync = 1'b1;
    for (int k = 0; k < 256; k++) begin
      int s = (k < 16) ? 0 : 1 + (k - 16) / 20;
      int p = (k < 16) ? k : (k - 16) % 20;
      logic on = rdy0 && (k <= drop);
      logic eb, eu;
      @(negedge clk);
      if (k == 0) fsync = 1'b0;
      eu = 1'b0;
      if (p == 0) begin
        has = 1'b0;
        if (on) begin
          if (exp_pops < limit) begin w = wgen(exp_pops); exp_pops++; has = 1'b1; end
          else eu = 1'b1;
        end
      end
      eb = on && has && ((s == 0) ? w[15 - p] : w[19 - p]);
      check("R2 bit_cnt", bit_cnt, k);
      check("R2 slot_idx", slot_idx, s);
      if (!rdy0) check("R4 idle/R5 late ready", sdo, 0);
      else if (k > drop) check("R6 gated off", sdo, 0);
      else check("R3 serial data", sdo, eb);
      check("R8 underrun", underrun, eu);
      if (k == raise) cready = 1'b1;
      if (k == drop) cready = 1'b0;
    end
    check("R7 pops per frame", popped - pops0, exp_pops - pops0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R4 reset sdo", sdo, 0);
    check("R8 reset underrun", underrun, 0);
    check("R7 reset tx_ready", tx_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) run_frame(VEC[i]);
    check("R1 held sync", bit_cnt, 255);
    fsync = 1'b1; cready = 1'b0;
    @(negedge clk);
    check("R1 frame start", bit_cnt, 0);
    repeat (5) @(negedge clk);
    check("R1 sync held high", bit_cnt, 5);
    fsync = 1'b0;
    repeat (44) @(negedge clk);
    fsync = 1'b1;
    @(negedge clk);
    fsync = 1'b0;
    check("R1 resync bit_cnt", bit_cnt, 0);
    check("R1 resync slot_idx", slot_idx, 0);
    check("R4 idle after resync", sdo, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule